// File: doc/BRIEF.md
# Button Press Duration Classifier

This block watches one push button, times each press against a fixed hold threshold, and reports every finished press as either a short symbol (dot) or a long symbol (dash). The fast system clock is brought down to a slow hold-timing tick by a cascade of divider stages. A small saturating counter advances on that tick while the button stays down.

Two indicator outputs show the class the press would get if it ended now. The user can therefore release at the right moment. When the button is released, the block emits a single-cycle valid strobe together with a dash flag.

An enable input arms the block, and a clear input restarts the hold timing. The button passes through a two-flop synchronizer, and presses shorter than one tick are discarded as glitches. With the default parameters, a 100 MHz clock is divided by 1000 and then by 5000, which gives a 50 ms tick. A press that ends after four or more ticks, about 200 ms, is a dash.

Top module: `press_classifier`

## Requirements
- R1: After reset, `dot_led_o`, `dash_led_o`, `sym_valid_o` and `is_dash_o` are all 0.
- R2: A press that ends with 1 to DASH_MIN-1 ticks counted (default 1 to 3) produces one strobe on `sym_valid_o` with `is_dash_o` = 0.
- R3: A press that ends with DASH_MIN or more ticks counted produces one strobe with `is_dash_o` = 1.
- R4: A press released before its first tick produces no strobe.
- R5: `sym_valid_o` is high for exactly one clock per completed press and is never high on two consecutive clocks.
- R6: While the button is held and the block is enabled, `dot_led_o` is 1 when 1 to DASH_MIN-1 ticks have been counted, and `dash_led_o` is 1 from DASH_MIN ticks onward. The two indicators are never high together, and both are 0 before the first tick.
- R7: While `en_i` is 0, the button is ignored: no strobe is produced and both indicators stay 0.
- R8: A high `clr_i` zeroes the hold count and suppresses any strobe in that cycle. A button still held afterwards is timed again from zero.
- R9: The hold count saturates at 2^CNT_W-1 and does not wrap on very long holds, so those holds still classify as dash.
- R10: One tick corresponds to DIV_FAST*DIV_SLOW clocks of continuous hold, measured from the moment the synchronized button goes high.

Top module ports (tick timing is set by parameters DIV_FAST, DIV_SLOW, CNT_W and DASH_MIN):

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Arms the classifier when high |
| clr_i | input | 1 | Synchronous clear of hold timing |
| btn_i | input | 1 | Raw push button, high when pressed |
| dot_led_o | output | 1 | Live indicator: press currently classifies as dot |
| dash_led_o | output | 1 | Live indicator: press currently classifies as dash |
| sym_valid_o | output | 1 | One-clock strobe when a press completes |
| is_dash_o | output | 1 | Class of the strobed symbol: 0 dot, 1 dash |

## Verification
The bound checker covers several rules on every clock:
- the strobe is never longer than one cycle;
- the dash flag agrees with the hold count that was present just before the strobe;
- no strobe follows a zero count;
- the count stays at its ceiling while the button is held;
- a clear or a low enable blocks the strobe.

The correspondence between wall-clock hold time and symbol class can only be shown by the bench's timed presses. This includes the exact tick period, the live indicator progression, and re-timing after a mid-press clear. Those presses are random hold lengths placed midway between tick boundaries, plus directed glitch, saturation, enable and clear cases.

// File: rtl/press_cls_pkg.sv
package press_cls_pkg;
  typedef enum logic [1:0] {
    IND_OFF  = 2'd0,
    IND_DOT  = 2'd1,
    IND_DASH = 2'd2
  } ind_e;
endpackage

// File: rtl/press_div_stage.sv
module press_div_stage #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic step_i,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (step_i)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign tick_o = run_i & step_i & (cnt_q == LAST);
endmodule

// File: rtl/press_btn_sync.sv
module press_btn_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_i,
  output logic held_o,
  output logic fall_o
);
  logic q1, q2, q3;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q1 <= 1'b0;
      q2 <= 1'b0;
      q3 <= 1'b0;
    end else begin
      q1 <= btn_i;
      q2 <= q1;
      q3 <= q2;
    end
  end

  assign held_o = q2;
  assign fall_o = q3 & ~q2;
endmodule

// File: rtl/press_hold_cnt.sv
module press_hold_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_o <= '0;
    else if (!run_i)                 cnt_o <= '0;
    else if (tick_i && cnt_o != CMAX) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/press_classifier.sv
module press_classifier #(
  parameter int unsigned DIV_FAST = 1000,
  parameter int unsigned DIV_SLOW = 5000,
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned DASH_MIN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  input  logic btn_i,
  output logic dot_led_o,
  output logic dash_led_o,
  output logic sym_valid_o,
  output logic is_dash_o
);
  import press_cls_pkg::*;

  localparam int unsigned NSTG = 2;
  localparam int unsigned STG_DIV [NSTG] = '{DIV_FAST, DIV_SLOW};
  localparam logic [CNT_W-1:0] DASH_CNT = CNT_W'(DASH_MIN);

  logic             held, fall, run, rel_ev, tick;
  logic [NSTG:0]    step;
  logic [CNT_W-1:0] hold_cnt;
  logic             valid_q, dash_q;
  ind_e             ind;

  press_btn_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .btn_i  (btn_i),
    .held_o (held),
    .fall_o (fall)
  );

  // timing runs only while an armed press is in progress
  assign run    = held & en_i & ~clr_i;
  assign rel_ev = fall & en_i & ~clr_i;

  assign step[0] = run;
  for (genvar g = 0; g < NSTG; g++) begin : g_div
    press_div_stage #(.DIV(STG_DIV[g])) u_stg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run),
      .step_i (step[g]),
      .tick_o (step[g+1])
    );
  end
  assign tick = step[NSTG];

  press_hold_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_i (tick),
    .cnt_o  (hold_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      dash_q  <= 1'b0;
    end else begin
      valid_q <= rel_ev & (hold_cnt != '0);
      if (rel_ev && hold_cnt != '0) dash_q <= (hold_cnt >= DASH_CNT);
    end
  end

  always_comb begin
    ind = IND_OFF;
    if (held && en_i) begin
      if (hold_cnt >= DASH_CNT)  ind = IND_DASH;
      else if (hold_cnt != '0)   ind = IND_DOT;
    end
  end

  assign dot_led_o   = (ind == IND_DOT);
  assign dash_led_o  = (ind == IND_DASH);
  assign sym_valid_o = valid_q;
  assign is_dash_o   = dash_q;
endmodule

// File: rtl/press_classifier_chk.sv
module press_classifier_chk #(
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned DASH_MIN = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             clr_i,
  input logic             held_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             dot_led_i,
  input logic             dash_led_i,
  input logic             sym_valid_i,
  input logic             is_dash_i
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] DASH_CNT = CNT_W'(DASH_MIN);

  // R5
  a_r5_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_i |=> !sym_valid_i);
  // R6
  a_r6_ind_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dot_led_i && dash_led_i));
  // R3
  a_r3_dash_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_i |-> (is_dash_i == ($past(cnt_i) >= DASH_CNT)));
  // R4
  a_r4_no_glitch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_i |-> ($past(cnt_i) != '0));
  // R9
  a_r9_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == CMAX && held_i && en_i && !clr_i) |=> (cnt_i == CMAX));
  // R7
  a_r7_en_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sym_valid_i);
  // R8
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!sym_valid_i && cnt_i == '0));
endmodule

bind press_classifier press_classifier_chk #(
  .CNT_W    (CNT_W),
  .DASH_MIN (DASH_MIN)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .clr_i       (clr_i),
  .held_i      (held),
  .cnt_i       (hold_cnt),
  .dot_led_i   (dot_led_o),
  .dash_led_i  (dash_led_o),
  .sym_valid_i (sym_valid_o),
  .is_dash_i   (is_dash_o)
);

// File: tb/press_classifier_tb.sv
module press_classifier_tb;
  localparam int DIV_FAST = 4;
  localparam int DIV_SLOW = 5;
  localparam int P        = DIV_FAST * DIV_SLOW;
  localparam int DASH_MIN = 4;
  localparam int CMAX     = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, clr = 1'b0, btn = 1'b0;
  logic dot_led, dash_led, sym_valid, is_dash;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  press_classifier #(
    .DIV_FAST (DIV_FAST),
    .DIV_SLOW (DIV_SLOW),
    .CNT_W    (4),
    .DASH_MIN (DASH_MIN)
  ) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .en_i        (en),
    .clr_i       (clr),
    .btn_i       (btn),
    .dot_led_o   (dot_led),
    .dash_led_o  (dash_led),
    .sym_valid_o (sym_valid),
    .is_dash_o   (is_dash)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // 0 none, 1 dot, 2 dash, for a press ending with k ticks counted
  function automatic int exp_class(input int k);
    int c;
    c = (k > CMAX) ? CMAX : k;
    if (c == 0) return 0;
    return (c >= DASH_MIN) ? 2 : 1;
  endfunction

  // watch the outputs after release; returns pulse cycles and last flag
  task automatic observe(output int pulses, output int flag);
    pulses = 0;
    flag = -1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (sym_valid) begin
        pulses++;
        flag = is_dash;
      end
    end
  endtask

  task automatic press(input int k, input bit armed, input string req);
    int pulses, flag, ec;
    ec = armed ? exp_class(k) : 0;
    btn = 1'b1;
    repeat (k * P + P / 2) @(negedge clk);
    check(dot_led == (ec == 1), {req, " R6 dot indicator"}, dot_led, ec == 1);
    check(dash_led == (ec == 2), {req, " R6 dash indicator"}, dash_led, ec == 2);
    btn = 1'b0;
    observe(pulses, flag);
    check(pulses == (ec != 0 ? 1 : 0), {req, " R5 strobe cycles"}, pulses, ec != 0);
    if (ec != 0)
      check(flag == (ec == 2 ? 1 : 0), {req, " R2/R3 is_dash"}, flag, ec == 2);
    repeat (2 + $urandom % 5) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int pulses, flag;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(!dot_led && !dash_led && !sym_valid && !is_dash, "R1 reset outputs",
          {dot_led, dash_led, sym_valid, is_dash}, 0);
    rst_n = 1'b1;
    en = 1'b1;
    repeat (3) @(negedge clk);
    check(!dot_led && !dash_led && !sym_valid, "R1 idle after reset",
          {dot_led, dash_led, sym_valid}, 0);

    // directed corners
    press(0, 1'b1, "R4 glitch");
    press(1, 1'b1, "R2 one tick");
    press(3, 1'b1, "R2 last dot");
    press(4, 1'b1, "R3 first dash");
    press(25, 1'b1, "R9 saturated hold");

    // R10 tick period
    btn = 1'b1;
    repeat (P - 4) @(negedge clk);
    check(!dot_led, "R10 no tick before period", dot_led, 0);
    repeat (10) @(negedge clk);
    check(dot_led, "R10 tick after period", dot_led, 1);
    btn = 1'b0;
    observe(pulses, flag);
    check(pulses == 1 && flag == 0, "R10 single tick gives dot", pulses, 1);
    repeat (4) @(negedge clk);

    // R7 enable low
    en = 1'b0;
    press(6, 1'b0, "R7 disabled");
    en = 1'b1;
    repeat (4) @(negedge clk);

    // R8 clear mid-press restarts timing
    btn = 1'b1;
    repeat (5 * P + P / 2) @(negedge clk);
    check(dash_led, "R8 dash before clear", dash_led, 1);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    @(negedge clk);
    check(!dot_led && !dash_led, "R8 indicators cleared", {dot_led, dash_led}, 0);
    repeat (2 * P + P / 2) @(negedge clk);
    btn = 1'b0;
    observe(pulses, flag);
    check(pulses == 1 && flag == 0, "R8 retimed press is dot", flag, 0);
    repeat (4) @(negedge clk);

    // R8 clear exactly at release suppresses strobe
    btn = 1'b1;
    repeat (3 * P + P / 2) @(negedge clk);
    btn = 1'b0;
    clr = 1'b1;
    repeat (4) @(negedge clk);
    clr = 1'b0;
    observe(pulses, flag);
    check(pulses == 0, "R8 clear at release no strobe", pulses, 0);

    // random presses
    for (int i = 0; i < 60; i++) begin
      press($urandom % 22, 1'b1, "R2/R3 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule